// File: doc/BRIEF.md
# I2C Master SCL Prescaler and Phase Timer

This block produces the serial clock of an I2C master. The functional clock first passes through a programmable prescaler that yields an internal tick. Two half-period counters then shape SCL: one sets the low time and one sets the high time. Each half-period register carries two count fields. One field is for fast/standard timing and one is for high-speed timing. Every programmed count gets six extra units added.

A high-speed transfer has two parts. The master-code part runs at fast/standard timing from the low-order fields, and it counts prescaled ticks. When high-speed mode is set and the bit engine pulses a phase-switch strobe, the timer moves to the data part at the start of the next low phase. The data part uses the high-order fields and counts undivided functional-clock cycles. Four configuration registers are written through a small write port. SCL rests high while the block is disabled. Clock stretching and the bit engine are outside this block.

Top module: `i2c_scl_timer`

## Requirements
- R1: A synchronous active-low reset drives SCL high and clears the prescaler, both half-period registers and the high-speed mode bit. After reset, an enabled timer produces low and high halves of exactly 6 cycles each.
- R2: While `enable` is low, SCL is high from the first clock edge after `enable` falls.
- R3: On the first clock edge with `enable` high after a disabled period, SCL goes low and a low half begins.
- R4: In fast/standard timing, a low half lasts (low field + 6) x (prescaler + 1) functional-clock cycles and a high half lasts (high field + 6) x (prescaler + 1) cycles. The low field is bits 7:0 of the low register and the high field is bits 7:0 of the high register.
- R5: A write with `wr_en` high stores `wr_data` in the register chosen by `wr_sel`: 0 is the prescaler (bits 7:0), 1 is the low register, 2 is the high register, and 3 is the control register, whose bit 12 selects high-speed mode.
- R6: With high-speed mode set and no phase-switch strobe, timing stays fast/standard.
- R7: With high-speed mode set, a `phase_sw` strobe takes effect at the next start of a low half. From then on, a low half lasts (low bits 15:8 + 6) cycles and a high half lasts (high bits 15:8 + 6) cycles of the functional clock, and the prescaler plays no part.
- R8: A `phase_sw` strobe while high-speed mode is clear has no effect: later halves keep fast/standard timing.
- R9: Disabling the timer leaves the high-speed data part. The next enable starts again in fast/standard timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Register select: 0 prescaler, 1 low, 2 high, 3 control |
| wr_data | input | 16 | Write data |
| enable | input | 1 | Run the SCL timer |
| phase_sw | input | 1 | Switch from master-code timing to high-speed data timing |
| scl_o | output | 1 | Generated serial clock |

## Verification
A wrong prescaler count or field choice shows up as a wrong half-period length at SCL. This is visible on the very next edge after the wrong state, so the bench times every half in clock cycles and compares it with the formula. A stuck or early switch to high-speed timing shows within one SCL period, as a half that is a factor of (prescaler + 1) too short or too long. A failure to return to idle shows on the first cycle after `enable` falls.

// File: rtl/i2c_sclgen_pkg.sv
// Shared constants and register-select type for the SCL timer.
package i2c_sclgen_pkg;
    localparam int REG_W      = 16;  // width of every configuration register
    localparam int HS_BIT     = 12;  // control bit that selects high-speed mode
    localparam int FIELD_W    = 8;   // width of one count field
    localparam int ADD_CYCLES = 6;   // fixed units added to every half period

    typedef enum logic [1:0] {
        SEL_PRESCALE = 2'd0,
        SEL_LOW      = 2'd1,
        SEL_HIGH     = 2'd2,
        SEL_CTRL     = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/sclgen_regs.sv
// Configuration registers of the SCL timer.
// Holds the prescaler, the low and high half-period registers (two packed
// count fields each) and the high-speed mode bit. It assumes writes are
// single-cycle strobes. A prescaler write is flagged so that the divider
// can restart cleanly.
module sclgen_regs
    import i2c_sclgen_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [REG_W-1:0]     wr_data,
    output logic [PSC_W-1:0]     psc_q,
    output logic [1:0][REG_W-1:0] half_q,   // [0] low register, [1] high register
    output logic                 hs_mode_q,
    output logic                 psc_wr
);
    cfg_sel_e sel;
    assign sel    = cfg_sel_e'(wr_sel);
    assign psc_wr = wr_en && (sel == SEL_PRESCALE);

    // Store written values; reset clears every register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q     <= '0;
            half_q    <= '0;
            hs_mode_q <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_PRESCALE: psc_q     <= wr_data[PSC_W-1:0];
                SEL_LOW:      half_q[0] <= wr_data;
                SEL_HIGH:     half_q[1] <= wr_data;
                SEL_CTRL:     hs_mode_q <= wr_data[HS_BIT];
                default:      ;
            endcase
        end
    end

    // A register that was not addressed keeps its value.
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(psc_q) && $stable(half_q) && $stable(hs_mode_q))); // R5
endmodule

// File: rtl/sclgen_prescaler.sv
// Prescaler of the SCL timer.
// Divides the functional clock by (psc + 1) and gives a one-cycle tick.
// It assumes the count is held at zero while the timer is not running or
// while the prescaler is being rewritten, so the first tick after a start
// comes exactly psc + 1 cycles later.
module sclgen_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt;
    logic             wrap;

    assign wrap = (pcnt >= psc);
    assign tick = run && !restart && wrap;

    // Count functional-clock cycles up to the prescaler value, then wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!run || restart || wrap) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    AST_PSC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt == '0)); // R4
    AST_PSC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= psc); // R4
endmodule

// File: rtl/sclgen_phase.sv
// Half-period sequencer of the SCL timer.
// Times the low and high halves of SCL, each lasting its field plus a fixed
// number of steps. In master-code timing a step is a prescaler tick and the
// fields are the low bytes; in the high-speed data part every clock is a step
// and the fields are the high bytes. It assumes the count registers are not
// rewritten while the timer runs.
module sclgen_phase
    import i2c_sclgen_pkg::*;
#(
    parameter int CNT_W = FIELD_W,
    parameter int ADD   = ADD_CYCLES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  hs_mode,
    input  logic                  phase_sw,
    input  logic                  pre_tick,
    input  logic [1:0][REG_W-1:0] half_regs,
    output logic                  running,
    output logic                  scl_o
);
    localparam int LIM_W = CNT_W + 1;
    localparam logic [LIM_W-1:0] ADD_L = LIM_W'(ADD);

    logic                 hs_data;   // high-speed data part active
    logic                 pend;      // strobe seen, waiting for the next low half
    logic [LIM_W-1:0]     cnt;
    logic [CNT_W-1:0]     fld [2];
    logic [LIM_W-1:0]     limit;
    logic                 step;
    logic                 last;
    logic                 go_hs;

    // Pick the field for each half from the part of the transfer in progress.
    for (genvar h = 0; h < 2; h++) begin : g_field
        assign fld[h] = hs_data ? half_regs[h][2*CNT_W-1:CNT_W]
                                : half_regs[h][CNT_W-1:0];
    end

    assign limit = {1'b0, fld[scl_o ? 1 : 0]} + ADD_L;
    assign step  = running && (hs_data || pre_tick);
    assign last  = (cnt >= limit - 1'b1);
    assign go_hs = scl_o && hs_mode && (pend || phase_sw);

    // Drive SCL, the half counter and the part of the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            scl_o   <= 1'b1;
            running <= 1'b0;
            cnt     <= '0;
            hs_data <= 1'b0;
            pend    <= 1'b0;
        end else if (!running) begin
            running <= 1'b1;
            scl_o   <= 1'b0;
            cnt     <= '0;
        end else begin
            pend <= (pend || phase_sw) && hs_mode && !hs_data;
            if (step) begin
                if (last) begin
                    cnt   <= '0;
                    scl_o <= !scl_o;
                    if (go_hs) begin
                        hs_data <= 1'b1;
                        pend    <= 1'b0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (!hs_mode) begin
                hs_data <= 1'b0;
                pend    <= 1'b0;
            end
        end
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> scl_o); // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !running) |=> (!scl_o && running)); // R3
    AST_EDGE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && $past(enable) && (scl_o != $past(scl_o))) |-> $past(step)); // R4
    AST_HS_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_mode |=> !hs_data); // R8
    AST_HS_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_data) |-> !scl_o); // R7
    AST_HS_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !hs_data); // R9
endmodule

// File: rtl/i2c_scl_timer.sv
// Top of the I2C master SCL prescaler and phase timer.
// Joins the configuration registers, the prescaler and the half-period
// sequencer. It assumes a single functional clock and a synchronous
// active-low reset.
module i2c_scl_timer
    import i2c_sclgen_pkg::*;
#(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             enable,
    input  logic             phase_sw,
    output logic             scl_o
);
    logic [PSC_W-1:0]      psc_q;
    logic [1:0][REG_W-1:0] half_q;
    logic                  hs_mode_q;
    logic                  psc_wr;
    logic                  running;
    logic                  pre_tick;

    sclgen_regs #(.PSC_W(PSC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .psc_q     (psc_q),
        .half_q    (half_q),
        .hs_mode_q (hs_mode_q),
        .psc_wr    (psc_wr)
    );

    sclgen_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (psc_wr),
        .psc     (psc_q),
        .tick    (pre_tick)
    );

    sclgen_phase #(.CNT_W(FIELD_W), .ADD(ADD_CYCLES)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .hs_mode   (hs_mode_q),
        .phase_sw  (phase_sw),
        .pre_tick  (pre_tick),
        .half_regs (half_q),
        .running   (running),
        .scl_o     (scl_o)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> scl_o); // R1
endmodule

// File: tb/i2c_scl_timer_test.sv
module i2c_scl_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        enable = 1'b0;
    logic        phase_sw = 1'b0;
    logic        scl_o;

    int tests = 0;
    int fails = 0;
    bit reported = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    i2c_scl_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .enable(enable), .phase_sw(phase_sw), .scl_o(scl_o)
    );

    // Vector table: prescaler, low register, high register (high bytes unused in fast/standard)
    localparam int NV = 4;
    localparam logic [7:0]  V_PSC  [NV] = '{8'd0, 8'd1, 8'd3, 8'd0};
    localparam logic [15:0] V_LOW  [NV] = '{16'h5500, 16'hAA04, 16'h010A, 16'h33C8};
    localparam logic [15:0] V_HIGH [NV] = '{16'h7700, 16'h0102, 16'hFF01, 16'h0009};

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
        end
    endtask

    task automatic check(input int act, input int exp, input string req);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Wait, sampling at falling edges, until SCL reads low.
    task automatic wait_low();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (scl_o !== 1'b0 && n < 5000);
    endtask

    // Length in cycles of the half currently in progress.
    task automatic half(output int n);
        logic v;
        v = scl_o;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (scl_o === v && n < 5000);
    endtask

    task automatic start_run();
        @(negedge clk);
        enable = 1'b1;
        wait_low();
    endtask

    task automatic stop_run();
        @(negedge clk);
        enable = 1'b0;
        phase_sw = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int d;
        int el, eh;
        repeat (3) @(negedge clk);
        check(int'(scl_o), 1, "R1 scl high in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(scl_o), 1, "R2 scl high while disabled");

        // R4/R5 table walk: fast/standard timing per vector
        for (int i = 0; i < NV; i++) begin
            write_reg(2'd0, {8'h00, V_PSC[i]});
            write_reg(2'd1, V_LOW[i]);
            write_reg(2'd2, V_HIGH[i]);
            write_reg(2'd3, 16'h0000);
            el = (int'(V_LOW[i][7:0]) + 6) * (int'(V_PSC[i]) + 1);
            eh = (int'(V_HIGH[i][7:0]) + 6) * (int'(V_PSC[i]) + 1);
            @(negedge clk);
            enable = 1'b1;
            @(negedge clk);
            check(int'(scl_o), 0, "R3 low on first enabled edge");
            half(d); check(d, el, "R4 first low half");
            half(d); check(d, eh, "R4 first high half");
            half(d); check(d, el, "R4 second low half");
            half(d); check(d, eh, "R4 second high half");
            stop_run();
            check(int'(scl_o), 1, "R2 idle after disable");
        end

        // High-speed configuration: psc 2, fs low 4 high 3, hs low 1 high 0
        write_reg(2'd0, 16'h0002);
        write_reg(2'd1, 16'h0104);
        write_reg(2'd2, 16'h0003);

        // R8: strobe with high-speed mode clear
        write_reg(2'd3, 16'h0000);
        start_run();
        phase_sw = 1'b1;
        half(d); check(d, 30, "R8 low before strobe");
        phase_sw = 1'b0;
        half(d); check(d, 27, "R8 high after ignored strobe");
        half(d); check(d, 30, "R8 low stays fast/standard");
        stop_run();

        // R6: high-speed mode set, no strobe
        write_reg(2'd3, 16'h1000);
        start_run();
        half(d); check(d, 30, "R6 master-code low");
        half(d); check(d, 27, "R6 master-code high");
        half(d); check(d, 30, "R6 low without strobe");

        // R7: strobe moves to high-speed timing at the next low half
        stop_run();
        start_run();
        phase_sw = 1'b1;
        half(d); check(d, 30, "R7 low during strobe");
        phase_sw = 1'b0;
        half(d); check(d, 27, "R7 high keeps master-code timing");
        half(d); check(d, 7, "R7 high-speed low half");
        half(d); check(d, 6, "R7 high-speed high half");
        half(d); check(d, 7, "R7 high-speed low half again");

        // R9: disabling leaves the high-speed part
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(int'(scl_o), 1, "R2 idle one edge after disable");
        enable = 1'b1;
        wait_low();
        half(d); check(d, 30, "R9 re-enable in master-code timing");
        half(d); check(d, 27, "R9 high in master-code timing");

        // R1: reset mid-run clears all registers
        @(negedge clk);
        rst_n = 1'b0;
        enable = 1'b0;
        @(negedge clk);
        check(int'(scl_o), 1, "R1 scl high after reset");
        rst_n = 1'b1;
        start_run();
        phase_sw = 1'b1;
        half(d); check(d, 6, "R1 cleared low half");
        phase_sw = 1'b0;
        half(d); check(d, 6, "R1 cleared high half");
        stop_run();

        report();
        $finish;
    end
endmodule